// File: doc/BRIEF.md
# Paging frame decode selector

This block tells a paging receiver, for every frame, whether the current frame should be decoded and which transmission phase to pull out of it. A host configures it by streaming a four-byte control packet over a byte-wide valid/ready write port. The receiver front end supplies the current frame number (0 to 127), a tick at the start of each block with that block's index, the system collapse value and an eight-bit vector of assigned frames.

Two frame sources feed the decode decision. Assigned-frame bits repeat through the 128-frame cycle according to the collapse value. Force bits pick one exact frame among frames 0 to 7 and ignore the collapse value. The phase mode (single-phase flag and phase number) is double-buffered. While the receiver is on, a new mode waits in a shadow copy until the first block of the next frame, so a frame is never decoded under a mix of two modes.

The write port applies back-pressure in one way only. `wr_ready` is low while reset is asserted and high on every cycle after that, so a byte is taken on each cycle where `wr_valid` is high once reset has been released. A byte flagged with `wr_first` always opens a new packet, and any packet still in progress is dropped.

Top module: `frame_decode_sel`

## Requirements
- R1: `wr_ready` is 0 during reset and 1 on every cycle after reset is released. A byte is taken on each clock edge where `wr_valid` and `wr_ready` are both high.
- R2: A packet is four bytes sent in this order: an identifier (must be 0x02, and carries `wr_first`), a force byte, a phase byte and a final byte whose content is ignored. In the phase byte, bit 6 is the single-phase flag and bits 5:4 are the phase number.
- R3: Force bit n (bit n of the force byte) enables decoding of frame n alone, whatever the collapse value. A new force byte takes effect at the clock edge that takes the fourth byte.
- R4: For collapse value c, assigned bit k enables every frame whose number modulo 2^c equals k. Bits with k of 2^c or more enable nothing.
- R5: `decode_en` is the OR of the assigned-frame match and the force match. It is 0 when neither source matches.
- R6: A packet whose identifier is not 0x02, or that stops before its fourth byte, changes no setting.
- R7: While `rx_on` is high, a new single-phase flag or phase number reaches `solo_phase`/`phase_sel` only at the edge where `block_tick` is high with `block_idx` equal to 0. Block ticks with any other index leave the outputs unchanged.
- R8: After reset, the force bits, the single-phase flag and the phase number are all 0.
- R9: While `rx_on` is low, a committed phase mode appears on the outputs at the edge that takes the fourth byte. A mode still waiting when `rx_on` falls appears one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host byte valid |
| wr_first | input | 1 | Marks the first (identifier) byte of a packet |
| wr_data | input | 8 | Host byte |
| wr_ready | output | 1 | Byte accepted when high together with wr_valid |
| rx_on | input | 1 | Receiver is running |
| block_tick | input | 1 | Pulse at the start of each block |
| block_idx | input | 4 | Index of the block that is starting |
| frame_num | input | 7 | Current frame number |
| collapse | input | 3 | System collapse value |
| assign_mask | input | 8 | Assigned-frame bits |
| decode_en | output | 1 | Decode the current frame |
| solo_phase | output | 1 | Decode a single phase only |
| phase_sel | output | 2 | Phase to decode when solo_phase is high |

## Verification
A force register holding a wrong value shows on `decode_en` as soon as `frame_num` equals the affected frame. Checks set the frame number directly, so the wrong value is seen in the same cycle. Corrupt packet-assembly state, such as a byte counter that is off by one or an identifier latched wrongly, shows one edge after the fourth byte, either as a setting that did not change or as one that changed when it should not have. A stale shadow or pending flag stays hidden until the block-0 tick or the fall of `rx_on`. It then shows on `solo_phase` and `phase_sel` one edge later, so each deferred-mode test probes the outputs both before and after that event.

// File: rtl/fds_pkg.sv
package fds_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned PHASE_W  = 2;
  localparam int unsigned SOLO_BIT = 6;
  localparam int unsigned SEL_LSB  = 4;

  typedef struct packed {
    logic               solo;
    logic [PHASE_W-1:0] sel;
  } phase_cfg_t;
endpackage

// File: rtl/fds_pkt_rx.sv
module fds_pkt_rx
  import fds_pkg::*;
#(
  parameter logic [BYTE_W-1:0] PKT_ID = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic              wr_first,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              commit,
  output logic [BYTE_W-1:0] force_new,
  output phase_cfg_t        phase_new
);
  localparam logic [1:0] SLOT_LAST = 2'd3;

  logic              rdy_q;
  logic [1:0]        slot_q;
  logic              id_ok_q;
  logic [BYTE_W-1:0] frc_byte_q;
  logic [BYTE_W-1:0] ph_byte_q;
  logic              take;

  assign wr_ready = rdy_q;
  assign take     = wr_valid && rdy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q     <= '0;
      id_ok_q    <= 1'b0;
      frc_byte_q <= '0;
      ph_byte_q  <= '0;
    end else if (take) begin
      if (wr_first) begin
        slot_q  <= 2'd1;
        id_ok_q <= (wr_data == PKT_ID);
      end else begin
        case (slot_q)
          2'd1: begin frc_byte_q <= wr_data; slot_q <= 2'd2; end
          2'd2: begin ph_byte_q  <= wr_data; slot_q <= 2'd3; end
          2'd3: slot_q <= 2'd0;
          default: slot_q <= 2'd0;
        endcase
      end
    end
  end

  assign commit        = take && !wr_first && (slot_q == SLOT_LAST) && id_ok_q;
  assign force_new     = frc_byte_q;
  assign phase_new.solo = ph_byte_q[SOLO_BIT];
  assign phase_new.sel  = ph_byte_q[SEL_LSB +: PHASE_W];
endmodule

// File: rtl/fds_frame_match.sv
module fds_frame_match #(
  parameter int unsigned FRAME_W = 7,
  parameter int unsigned MASK_W  = 8,
  parameter int unsigned COLL_W  = 3
) (
  input  logic [FRAME_W-1:0] frame_num,
  input  logic [COLL_W-1:0]  collapse,
  input  logic [MASK_W-1:0]  assign_mask,
  input  logic [MASK_W-1:0]  force_mask,
  output logic               decode_en
);
  logic [FRAME_W-1:0] low_mask;
  logic [FRAME_W-1:0] residue;
  logic [MASK_W-1:0]  asg_hit;
  logic [MASK_W-1:0]  frc_hit;

  always_comb begin
    low_mask = '0;
    for (int i = 0; i < int'(FRAME_W); i++) begin
      if (i < int'(collapse)) low_mask[i] = 1'b1;
    end
    residue = frame_num & low_mask;
  end

  for (genvar k = 0; k < int'(MASK_W); k++) begin : g_slot
    assign asg_hit[k] = assign_mask[k] && (residue   == FRAME_W'(k));
    assign frc_hit[k] = force_mask[k]  && (frame_num == FRAME_W'(k));
  end

  assign decode_en = (|asg_hit) || (|frc_hit);
endmodule

// File: rtl/fds_phase_ctl.sv
module fds_phase_ctl
  import fds_pkg::*;
#(
  parameter int unsigned BLK_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_on,
  input  logic             block_tick,
  input  logic [BLK_W-1:0] block_idx,
  input  logic             commit,
  input  phase_cfg_t       cfg_new,
  output phase_cfg_t       cfg_act,
  output logic             pend
);
  phase_cfg_t shadow_q, act_q;
  logic       pend_q;
  logic       frame_edge;

  assign frame_edge = block_tick && (block_idx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      act_q    <= '0;
      pend_q   <= 1'b0;
    end else if (commit) begin
      shadow_q <= cfg_new;
      if (rx_on) begin
        pend_q <= 1'b1;
      end else begin
        act_q  <= cfg_new;
        pend_q <= 1'b0;
      end
    end else if (pend_q && (!rx_on || frame_edge)) begin
      act_q  <= shadow_q;
      pend_q <= 1'b0;
    end
  end

  assign cfg_act = act_q;
  assign pend    = pend_q;
endmodule

// File: rtl/frame_decode_sel.sv
module frame_decode_sel
  import fds_pkg::*;
#(
  parameter int unsigned FRAME_W = 7,
  parameter int unsigned BLK_W   = 4,
  parameter int unsigned COLL_W  = 3,
  parameter logic [7:0]  PKT_ID  = 8'h02
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  input  logic               wr_first,
  input  logic [7:0]         wr_data,
  output logic               wr_ready,
  input  logic               rx_on,
  input  logic               block_tick,
  input  logic [BLK_W-1:0]   block_idx,
  input  logic [FRAME_W-1:0] frame_num,
  input  logic [COLL_W-1:0]  collapse,
  input  logic [7:0]         assign_mask,
  output logic               decode_en,
  output logic               solo_phase,
  output logic [1:0]         phase_sel
);
  localparam int unsigned MASK_W = BYTE_W;

  logic              commit;
  logic [MASK_W-1:0] force_new;
  logic [MASK_W-1:0] force_q;
  phase_cfg_t        phase_new;
  phase_cfg_t        phase_act;
  logic              phase_pend;

  fds_pkt_rx #(.PKT_ID(PKT_ID)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_first  (wr_first),
    .wr_data   (wr_data),
    .wr_ready  (wr_ready),
    .commit    (commit),
    .force_new (force_new),
    .phase_new (phase_new)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      force_q <= '0;
    else if (commit) force_q <= force_new;
  end

  fds_frame_match #(.FRAME_W(FRAME_W), .MASK_W(MASK_W), .COLL_W(COLL_W)) u_match (
    .frame_num   (frame_num),
    .collapse    (collapse),
    .assign_mask (assign_mask),
    .force_mask  (force_q),
    .decode_en   (decode_en)
  );

  fds_phase_ctl #(.BLK_W(BLK_W)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_on      (rx_on),
    .block_tick (block_tick),
    .block_idx  (block_idx),
    .commit     (commit),
    .cfg_new    (phase_new),
    .cfg_act    (phase_act),
    .pend       (phase_pend)
  );

  assign solo_phase = phase_act.solo;
  assign phase_sel  = phase_act.sel;
endmodule

// File: rtl/fds_checker.sv
module fds_checker #(
  parameter int unsigned FRAME_W = 7,
  parameter int unsigned BLK_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_valid,
  input logic               wr_ready,
  input logic               rx_on,
  input logic               block_tick,
  input logic [BLK_W-1:0]   block_idx,
  input logic [FRAME_W-1:0] frame_num,
  input logic [7:0]         assign_mask,
  input logic               decode_en,
  input logic               solo_phase,
  input logic [1:0]         phase_sel,
  input logic [7:0]         force_q,
  input logic               phase_pend
);
  assert_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> wr_ready);

  assert_force_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_num < FRAME_W'(8)) && force_q[frame_num[2:0]] |-> decode_en);

  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (force_q == 8'h00) && (assign_mask == 8'h00) |-> !decode_en);

  assert_force_only_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(force_q) |-> $past(wr_valid && wr_ready));

  assert_phase_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rx_on) && !$past(block_tick && (block_idx == '0))
      |-> $stable(solo_phase) && $stable(phase_sel));

  assert_off_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_on |=> !phase_pend);
endmodule

bind frame_decode_sel fds_checker #(.FRAME_W(FRAME_W), .BLK_W(BLK_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .rx_on       (rx_on),
  .block_tick  (block_tick),
  .block_idx   (block_idx),
  .frame_num   (frame_num),
  .assign_mask (assign_mask),
  .decode_en   (decode_en),
  .solo_phase  (solo_phase),
  .phase_sel   (phase_sel),
  .force_q     (force_q),
  .phase_pend  (phase_pend)
);

// File: tb/frame_decode_sel_tb.sv
module frame_decode_sel_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0, wr_first = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_ready;
  logic       rx_on = 1'b0, block_tick = 1'b0;
  logic [3:0] block_idx = '0;
  logic [6:0] frame_num = '0;
  logic [2:0] collapse = '0;
  logic [7:0] assign_mask = '0;
  logic       decode_en, solo_phase;
  logic [1:0] phase_sel;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  frame_decode_sel u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_first(wr_first),
    .wr_data(wr_data), .wr_ready(wr_ready), .rx_on(rx_on),
    .block_tick(block_tick), .block_idx(block_idx), .frame_num(frame_num),
    .collapse(collapse), .assign_mask(assign_mask), .decode_en(decode_en),
    .solo_phase(solo_phase), .phase_sel(phase_sel)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b3, b2, b1, b0, input int nbytes);
    logic [7:0] seq [4];
    seq = '{b3, b2, b1, b0};
    for (int i = 0; i < nbytes; i++) begin
      @(negedge clk);
      wr_valid = 1'b1; wr_first = (i == 0); wr_data = seq[i];
      @(posedge clk);
    end
    @(negedge clk);
    wr_valid = 1'b0; wr_first = 1'b0;
  endtask

  task automatic probe(input string tag, input int fr, input logic exp);
    @(negedge clk);
    frame_num = 7'(fr);
    #1 chk(tag, {7'd0, decode_en}, {7'd0, exp});
  endtask

  task automatic phase_is(input string tag, input logic s, input logic [1:0] p);
    chk({tag, " solo"}, {7'd0, solo_phase}, {7'd0, s});
    chk({tag, " sel"},  {6'd0, phase_sel},  {6'd0, p});
  endtask

  task automatic t_reset;
    chk("R1 ready in reset", {7'd0, wr_ready}, 8'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", {7'd0, wr_ready}, 8'd1);
    phase_is("R8 reset", 1'b0, 2'd0);
    for (int f = 0; f < 8; f++) probe("R8 force clear", f, 1'b0);
  endtask

  task automatic t_force;
    collapse = 3'd5; assign_mask = 8'h00;
    send(8'h02, 8'h01, 8'h00, 8'h00, 4);
    probe("R3 frame 0", 0, 1'b1);
    probe("R3 frame 32 not forced", 32, 1'b0);
    probe("R3 frame 1", 1, 1'b0);
    send(8'h02, 8'h80, 8'h00, 8'hAA, 4);
    probe("R2 frame 7", 7, 1'b1);
    probe("R2 frame 0 dropped", 0, 1'b0);
    send(8'h02, 8'h00, 8'h00, 8'h00, 4);
  endtask

  task automatic t_assign;
    collapse = 3'd5; assign_mask = 8'h01;
    probe("R4 c5 f0", 0, 1'b1);
    probe("R4 c5 f32", 32, 1'b1);
    probe("R4 c5 f64", 64, 1'b1);
    probe("R4 c5 f96", 96, 1'b1);
    probe("R4 c5 f33", 33, 1'b0);
    collapse = 3'd0;
    probe("R4 c0 f77", 77, 1'b1);
    collapse = 3'd7; assign_mask = 8'h80;
    probe("R4 c7 f7", 7, 1'b1);
    probe("R4 c7 f127", 127, 1'b0);
    collapse = 3'd2; assign_mask = 8'h10;
    probe("R4 c2 k4 unused", 4, 1'b0);
    probe("R4 c2 k4 unused f0", 0, 1'b0);
  endtask

  task automatic t_or;
    collapse = 3'd3; assign_mask = 8'h02;
    send(8'h02, 8'h04, 8'h00, 8'h00, 4);
    probe("R5 assigned f9", 9, 1'b1);
    probe("R5 forced f2", 2, 1'b1);
    probe("R5 neither f3", 3, 1'b0);
    probe("R5 forced f10 no repeat", 10, 1'b0);
  endtask

  task automatic t_bad;
    assign_mask = 8'h00;
    send(8'h03, 8'hFF, 8'h70, 8'h00, 4);
    probe("R6 bad id f5", 5, 1'b0);
    probe("R6 bad id f2 kept", 2, 1'b1);
    phase_is("R6 bad id", 1'b0, 2'd0);
    send(8'h02, 8'hFF, 8'h70, 8'h00, 3);
    probe("R6 short f5", 5, 1'b0);
    phase_is("R6 short", 1'b0, 2'd0);
    send(8'h02, 8'h00, 8'h00, 8'h00, 4);
  endtask

  task automatic t_phase_off;
    rx_on = 1'b0;
    send(8'h02, 8'h00, 8'h60, 8'h00, 4);
    phase_is("R9 off immediate", 1'b1, 2'd2);
  endtask

  task automatic t_phase_on;
    rx_on = 1'b1;
    send(8'h02, 8'h01, 8'h10, 8'h00, 4);
    probe("R3 force live while on", 0, 1'b1);
    phase_is("R7 held", 1'b1, 2'd2);
    @(negedge clk); block_tick = 1'b1; block_idx = 4'd3;
    @(negedge clk); block_tick = 1'b0;
    phase_is("R7 block 3 ignored", 1'b1, 2'd2);
    @(negedge clk); block_tick = 1'b1; block_idx = 4'd0;
    @(negedge clk); block_tick = 1'b0;
    phase_is("R7 block 0 applied", 1'b0, 2'd1);
  endtask

  task automatic t_flush;
    send(8'h02, 8'h00, 8'h70, 8'h00, 4);
    phase_is("R9 held while on", 1'b0, 2'd1);
    @(negedge clk); rx_on = 1'b0;
    @(negedge clk);
    phase_is("R9 flushed on off", 1'b1, 2'd3);
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_force();
    t_assign();
    t_or();
    t_bad();
    t_phase_off();
    t_phase_on();
    t_flush();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end
endmodule